// File: doc/BRIEF.md
# Command Bus Hold and Parking Driver

This block sits between a memory command scheduler and the command/address pins of a DDR channel. Each command the scheduler hands over through a valid/ready handshake goes onto the pins and stays there for one, two or three clock cycles, chosen by a two-bit hold-mode setting. Chip-select for the addressed rank goes low only in the last of those cycles. A stretched command therefore has its address and command lines settled for one or two cycles before it is qualified. While a command is still being held, the scheduler sees ready low.

A parking-policy bit sets what the bus does when no command is in flight. With the bit clear, the bus drives only while the channel is active and is released when every rank has clock-enable low or the memory is in self-refresh or a deeper state. Idle cycles with the bit clear show a NOP code on the command lines. With the bit set, the bus always drives and keeps showing the last command and address, with chip-select high. Both settings sit in a small configuration register that is written through a strobe.

Top module: `cmd_stretch_drv`

## Requirements
- R1: After reset, the hold mode is 2N (10b) and the parking bit is 0. All chip-selects are high, the command lines show NOP (3'b111), the address is zero, the output enable is 0 and ready is 1.
- R2: Hold mode 00b holds each command for 1 cycle, 10b for 2 cycles and 11b for 3 cycles. Reserved value 01b behaves as 00b. The command and address pins carry the accepted values from the cycle after acceptance through the whole hold.
- R3: Bit i of the chip-select output is active-low and belongs to rank index i. It is low only in the final cycle of a held command, and only for the accepted rank. No more than one bit is ever low.
- R4: Ready is low in every held cycle except the final one. A command offered in the final cycle is accepted and appears on the pins in the next cycle, with no idle cycle in between.
- R5: In idle cycles all chip-selects are high. With the parking bit 0 the command lines show NOP (3'b111) and the address keeps its last value. With the parking bit 1 the command and address keep the last accepted command.
- R6: With the parking bit 0, the output enable is registered. It is 1 while a command is held, and otherwise equals (any rank clock-enable high) AND NOT self-refresh, one cycle after those inputs change.
- R7: With the parking bit 1, the output enable is 1 from the cycle after the bit is written, whatever the clock-enable and self-refresh inputs are.
- R8: A configuration write takes effect from the next cycle. A command already being held keeps the length that was in force when it was accepted.
- R9: A command offered while ready is low has no effect. The pins keep the held command, address and chip-select timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode_wr | input | 2 | Hold mode to write (00 1N, 10 2N, 11 3N, 01 reserved) |
| cfg_park_wr | input | 1 | Parking policy to write (1 = always drive) |
| cmd_valid | input | 1 | Scheduler offers a command |
| cmd_ready | output | 1 | Driver can accept a command this cycle |
| cmd_code | input | 3 | Command code lines (3'b111 = NOP) |
| cmd_addr | input | ADDR_W | Command address |
| cmd_rank | input | RANK_W | Target rank index |
| rank_cke | input | NRANK | Clock-enable state of each rank |
| rank_sr | input | 1 | Memory is in self-refresh or deeper |
| ddr_cs_n | output | NRANK | Active-low chip-selects |
| ddr_cmd | output | 3 | Command lines at the pins |
| ddr_addr | output | ADDR_W | Address lines at the pins |
| ddr_oe | output | 1 | Output enable of the command/address bus |

## Verification
The bench goes through every hold-mode encoding, including the reserved one, for every rank, under both parking policies. It also offers stray commands during holds. An off-by-one hold counter would drop chip-select one cycle early or late, and a decoder that treats 01b as anything but 1N would stretch that command. A ready that rises too early would let a stray command overwrite a held address. Back-to-back chains in each mode catch a driver that adds an idle cycle between commands. A mode rewritten in mid-hold catches a driver that re-reads the mode instead of latching it. Sweeps of clock-enable and self-refresh under both policies catch an output enable that releases the bus during a held command or ignores the parking bit.

// File: rtl/cmd_stretch_pkg.sv
// Shared types and helpers for the command hold driver.
// Assumes a three-line command code in which all ones means NOP.
package cmd_stretch_pkg;

    localparam int CMD_W = 3;
    localparam logic [CMD_W-1:0] CMD_NOP = '1;

    typedef enum logic [1:0] {
        HOLD_1N   = 2'b00,
        HOLD_RSVD = 2'b01,
        HOLD_2N   = 2'b10,
        HOLD_3N   = 2'b11
    } hold_mode_e;

    localparam hold_mode_e MODE_AT_RESET = HOLD_2N;

    // Number of pin cycles a command occupies for a given mode code.
    function automatic logic [1:0] hold_cycles(input logic [1:0] mode);
        case (mode)
            HOLD_2N: hold_cycles = 2'd2;
            HOLD_3N: hold_cycles = 2'd3;
            default: hold_cycles = 2'd1;   // 1N and reserved
        endcase
    endfunction

endpackage

// File: rtl/cs_cfg_regs.sv
// Configuration holder: hold mode and parking policy.
// Assumes writes come as a single-cycle strobe; new values apply next cycle.
module cs_cfg_regs
    import cmd_stretch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] mode_in,
    input  logic       park_in,
    output logic [1:0] mode_q,
    output logic       park_q
);

    // Capture configuration on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_AT_RESET;
            park_q <= 1'b0;
        end else if (wr) begin
            mode_q <= mode_in;
            park_q <= park_in;
        end
    end

endmodule

// File: rtl/cs_hold_seq.sv
// Hold sequencer: counts the pin cycles left for the current command.
// Ready is high when at most one held cycle remains, so a new command can
// follow with no gap. The length is latched at acceptance.
module cs_hold_seq
    import cmd_stretch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid,
    input  logic [1:0] mode,
    output logic       ready,
    output logic       accept,
    output logic       final_next,
    output logic       busy_next
);

    logic [1:0] left_q;
    logic [1:0] left_d;

    // Handshake and next remaining-cycle count.
    always_comb begin
        ready  = (left_q <= 2'd1);
        accept = valid && ready;
        if (accept)
            left_d = hold_cycles(mode);
        else if (left_q != 2'd0)
            left_d = left_q - 2'd1;
        else
            left_d = 2'd0;
        final_next = (left_d == 2'd1);
        busy_next  = (left_d != 2'd0);
    end

    // Remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= 2'd0;
        else
            left_q <= left_d;
    end

endmodule

// File: rtl/cs_pin_stage.sv
// Pin register stage: holds command, address and rank, and produces the
// active-low chip-selects and the NOP substitution for idle cycles.
// Assumes rank indices below NRANK; other indices select no rank.
module cs_pin_stage
    import cmd_stretch_pkg::*;
#(
    parameter int NRANK  = 2,
    parameter int ADDR_W = 14,
    localparam int RANK_W = (NRANK > 1) ? $clog2(NRANK) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              final_next,
    input  logic              busy_next,
    input  logic              park,
    input  logic [CMD_W-1:0]  cmd_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [RANK_W-1:0] rank_in,
    output logic [NRANK-1:0]  cs_n,
    output logic [CMD_W-1:0]  cmd_out,
    output logic [ADDR_W-1:0] addr_out
);

    logic [CMD_W-1:0]  last_cmd_q;
    logic [RANK_W-1:0] rank_q;
    logic [RANK_W-1:0] rank_sel;
    logic [NRANK-1:0]  cs_d;
    logic [NRANK-1:0]  cs_q;
    logic              show_q;

    // Rank that the next pin cycle belongs to.
    always_comb rank_sel = accept ? rank_in : rank_q;

    // One chip-select decoder per rank, active only in a final cycle.
    for (genvar i = 0; i < NRANK; i++) begin : g_cs
        always_comb cs_d[i] = !(final_next && (rank_sel == RANK_W'(i)));
    end

    // Capture accepted command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_cmd_q <= CMD_NOP;
            addr_out   <= '0;
            rank_q     <= '0;
        end else if (accept) begin
            last_cmd_q <= cmd_in;
            addr_out   <= addr_in;
            rank_q     <= rank_in;
        end
    end

    // Chip-select flops and the show-last-command flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= '1;
            show_q <= 1'b0;
        end else begin
            cs_q   <= cs_d;
            show_q <= busy_next || park;
        end
    end

    // Idle cycles without parking carry NOP on the command lines.
    always_comb begin
        cs_n    = cs_q;
        cmd_out = show_q ? last_cmd_q : CMD_NOP;
    end

endmodule

// File: rtl/cs_oe_ctrl.sv
// Output enable control for the command/address bus.
// Drives when parking is on, when a command is held, or when the channel is
// active (some rank has clock-enable high and memory is not self-refreshing).
module cs_oe_ctrl #(
    parameter int NRANK = 2
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             park,
    input  logic             busy_next,
    input  logic [NRANK-1:0] cke,
    input  logic             self_refresh,
    output logic             oe
);

    // Registered enable so it switches on the same edge as the pins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            oe <= 1'b0;
        else
            oe <= park || busy_next || ((|cke) && !self_refresh);
    end

endmodule

// File: rtl/cmd_stretch_drv.sv
// Top of the command hold driver. Accepts one command per handshake,
// holds it 1/2/3 cycles per the mode setting with chip-select in the last
// cycle only, and manages bus drive per the parking policy.
// Assumes NRANK >= 2 and a synchronous active-low reset.
module cmd_stretch_drv
    import cmd_stretch_pkg::*;
#(
    parameter int NRANK  = 2,
    parameter int ADDR_W = 14,
    localparam int RANK_W = (NRANK > 1) ? $clog2(NRANK) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_mode_wr,
    input  logic              cfg_park_wr,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [RANK_W-1:0] cmd_rank,
    input  logic [NRANK-1:0]  rank_cke,
    input  logic              rank_sr,
    output logic [NRANK-1:0]  ddr_cs_n,
    output logic [2:0]        ddr_cmd,
    output logic [ADDR_W-1:0] ddr_addr,
    output logic              ddr_oe
);

    logic [1:0] mode_q;
    logic       park_q;
    logic       accept;
    logic       final_next;
    logic       busy_next;

    cs_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .mode_in (cfg_mode_wr),
        .park_in (cfg_park_wr),
        .mode_q  (mode_q),
        .park_q  (park_q)
    );

    cs_hold_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (cmd_valid),
        .mode       (mode_q),
        .ready      (cmd_ready),
        .accept     (accept),
        .final_next (final_next),
        .busy_next  (busy_next)
    );

    cs_pin_stage #(.NRANK(NRANK), .ADDR_W(ADDR_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .final_next (final_next),
        .busy_next  (busy_next),
        .park       (park_q),
        .cmd_in     (cmd_code),
        .addr_in    (cmd_addr),
        .rank_in    (cmd_rank),
        .cs_n       (ddr_cs_n),
        .cmd_out    (ddr_cmd),
        .addr_out   (ddr_addr)
    );

    cs_oe_ctrl #(.NRANK(NRANK)) u_oe (
        .clk          (clk),
        .rst_n        (rst_n),
        .park         (park_q),
        .busy_next    (busy_next),
        .cke          (rank_cke),
        .self_refresh (rank_sr),
        .oe           (ddr_oe)
    );

endmodule

// File: rtl/cmd_stretch_chk.sv
// Protocol checker for the command hold driver, bound to the top module.
// Assumes it sees the top's ports plus the latched parking bit.
module cmd_stretch_chk #(
    parameter int NRANK  = 2,
    parameter int ADDR_W = 14
)(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic [NRANK-1:0]  ddr_cs_n,
    input logic [2:0]        ddr_cmd,
    input logic [ADDR_W-1:0] ddr_addr,
    input logic              ddr_oe,
    input logic              park_q
);

    // R3: never more than one rank selected.
    assert_cs_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ddr_cs_n));

    // R3: chip-select stays high in non-final held cycles.
    assert_cs_final_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |-> (&ddr_cs_n));

    // R4: pins do not move while the scheduler is held off.
    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> ($stable(ddr_cmd) && $stable(ddr_addr)));

    // R6: a selected rank always sees a driven bus.
    assert_cs_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(&ddr_cs_n) |-> ddr_oe);

    // R7: parking policy keeps the bus driven.
    assert_park_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        park_q |=> ddr_oe);

endmodule

bind cmd_stretch_drv cmd_stretch_chk #(.NRANK(NRANK), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .ddr_cs_n  (ddr_cs_n),
    .ddr_cmd   (ddr_cmd),
    .ddr_addr  (ddr_addr),
    .ddr_oe    (ddr_oe),
    .park_q    (park_q)
);

// File: tb/sim_cmd_stretch_drv.sv
module sim_cmd_stretch_drv;

    localparam int NRANK  = 2;
    localparam int ADDR_W = 14;
    localparam int RANK_W = 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_wr;
    logic [1:0]        cfg_mode_wr;
    logic              cfg_park_wr;
    logic              cmd_valid;
    logic              cmd_ready;
    logic [2:0]        cmd_code;
    logic [ADDR_W-1:0] cmd_addr;
    logic [RANK_W-1:0] cmd_rank;
    logic [NRANK-1:0]  rank_cke;
    logic              rank_sr;
    logic [NRANK-1:0]  ddr_cs_n;
    logic [2:0]        ddr_cmd;
    logic [ADDR_W-1:0] ddr_addr;
    logic              ddr_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    bit park_now = 0;

    always #2 clk = ~clk;

    cmd_stretch_drv #(.NRANK(NRANK), .ADDR_W(ADDR_W)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int len_of(input int m);
        return (m == 3) ? 3 : (m == 2) ? 2 : 1;
    endfunction

    function automatic logic idle_oe();
        return park_now || ((|rank_cke) && !rank_sr);
    endfunction

    task automatic set_cfg(input int m, input bit p);
        cfg_wr = 1'b1; cfg_mode_wr = 2'(m); cfg_park_wr = p;
        @(negedge clk);
        cfg_wr = 1'b0;
        park_now = p;
    endtask

    task automatic put(input logic [2:0] c, input logic [ADDR_W-1:0] a, input int r);
        cmd_valid = 1'b1; cmd_code = c; cmd_addr = a; cmd_rank = RANK_W'(r);
    endtask

    // Walk the n held cycles of (c,a,r); optionally offer stray commands.
    task automatic watch(input int n, input logic [2:0] c, input logic [ADDR_W-1:0] a,
                         input int r, input bit junk, input bit keep);
        for (int k = 1; k <= n; k++) begin
            logic [NRANK-1:0] ecs;
            @(negedge clk);
            ecs = (k == n) ? ~(NRANK'(1) << r) : '1;
            chk("R2 cmd", 32'(ddr_cmd), 32'(c));
            chk("R2 addr", 32'(ddr_addr), 32'(a));
            chk("R3 cs_n", 32'(ddr_cs_n), 32'(ecs));
            chk("R4 ready", 32'(cmd_ready), 32'(k == n));
            chk("R6 oe held", 32'(ddr_oe), 32'd1);
            if (k < n && junk) begin
                cmd_valid = 1'b1; cmd_code = ~c; cmd_addr = ~a; cmd_rank = ~RANK_W'(r);
            end else if (!(k == n && keep)) begin
                cmd_valid = 1'b0;
            end
        end
    endtask

    task automatic idle_chk(input logic [2:0] c, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        chk("R5 idle cs_n", 32'(ddr_cs_n), 32'(NRANK'('1)));
        chk("R5 idle cmd", 32'(ddr_cmd), park_now ? 32'(c) : 32'h7);
        chk("R5 idle addr", 32'(ddr_addr), 32'(a));
        chk("R9 ready idle", 32'(cmd_ready), 32'd1);
        chk("R6 idle oe", 32'(ddr_oe), 32'(idle_oe()));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_mode_wr = '0; cfg_park_wr = 1'b0;
        cmd_valid = 1'b0; cmd_code = '0; cmd_addr = '0; cmd_rank = '0;
        rank_cke = '0; rank_sr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", 32'(ddr_cs_n), 32'(NRANK'('1)));
        chk("R1 cmd", 32'(ddr_cmd), 32'h7);
        chk("R1 addr", 32'(ddr_addr), 32'h0);
        chk("R1 oe", 32'(ddr_oe), 32'h0);
        chk("R1 ready", 32'(cmd_ready), 32'h1);
        rank_cke = '1;
        // R1: default mode is 2N, default parking off
        put(3'd5, 14'h123, 1);
        watch(2, 3'd5, 14'h123, 1, 1'b0, 1'b0);
        idle_chk(3'd5, 14'h123);

        // R2/R3/R5/R9 sweep: every mode code, rank, policy, stray offers
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 4; m++) begin
                set_cfg(m, p[0]);
                for (int r = 0; r < NRANK; r++) begin
                    for (int j = 0; j < 2; j++) begin
                        logic [2:0] c;
                        logic [ADDR_W-1:0] a;
                        c = 3'((m + r + j) % 7);
                        a = ADDR_W'(m * 1000 + r * 100 + j * 10 + p + 7);
                        put(c, a, r);
                        watch(len_of(m), c, a, r, j[0], 1'b0);
                        idle_chk(c, a);
                    end
                end
            end
        end

        // R4 back-to-back chains in each real mode
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            set_cfg(m, 1'b0);
            put(3'd1, 14'h0A1, 0);
            watch(len_of(m), 3'd1, 14'h0A1, 0, 1'b0, 1'b1);
            put(3'd2, 14'h0B2, 1);
            watch(len_of(m), 3'd2, 14'h0B2, 1, 1'b0, 1'b1);
            put(3'd3, 14'h0C3, 0);
            watch(len_of(m), 3'd3, 14'h0C3, 0, 1'b0, 1'b0);
            idle_chk(3'd3, 14'h0C3);
        end

        // R8 mode rewritten during a 3N hold
        set_cfg(3, 1'b0);
        put(3'd4, 14'h2D4, 1);
        @(negedge clk);
        chk("R8 cycle1 cs_n", 32'(ddr_cs_n), 32'(NRANK'('1)));
        cmd_valid = 1'b0; cfg_wr = 1'b1; cfg_mode_wr = 2'b00; cfg_park_wr = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk("R8 cycle2 cs_n", 32'(ddr_cs_n), 32'(NRANK'('1)));
        chk("R8 cycle2 ready", 32'(cmd_ready), 32'd0);
        @(negedge clk);
        chk("R8 cycle3 cs_n", 32'(ddr_cs_n), 32'b01);
        chk("R8 cycle3 cmd", 32'(ddr_cmd), 32'd4);
        put(3'd6, 14'h3E6, 0);
        watch(1, 3'd6, 14'h3E6, 0, 1'b0, 1'b0);
        idle_chk(3'd6, 14'h3E6);

        // R6/R7 output enable sweep over clock-enable and self-refresh
        for (int p = 0; p < 2; p++) begin
            set_cfg(0, p[0]);
            for (int ck = 0; ck < 4; ck++) begin
                for (int s = 0; s < 2; s++) begin
                    rank_cke = NRANK'(ck); rank_sr = s[0];
                    @(negedge clk);
                    if (p == 1)
                        chk("R7 parked oe", 32'(ddr_oe), 32'd1);
                    else
                        chk("R6 oe", 32'(ddr_oe), 32'((ck != 0) && (s == 0)));
                end
            end
        end

        // R6: held command drives even with all ranks powered down
        set_cfg(2, 1'b0);
        rank_cke = '0; rank_sr = 1'b1;
        @(negedge clk);
        chk("R6 released", 32'(ddr_oe), 32'd0);
        put(3'd0, 14'h1F0, 1);
        watch(2, 3'd0, 14'h1F0, 1, 1'b0, 1'b0);
        idle_chk(3'd0, 14'h1F0);
        // R7: parking re-drives last command after a NOP idle period
        set_cfg(2, 1'b1);
        @(negedge clk);
        chk("R7 oe", 32'(ddr_oe), 32'd1);
        chk("R5 parked cmd", 32'(ddr_cmd), 32'd0);
        chk("R5 parked addr", 32'(ddr_addr), 32'h1F0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule